// File: doc/BRIEF.md
# Programmable Periodic Interrupt Generator

The block turns a 32768 Hz time-base strobe into a periodic tick at a rate chosen by software. The strobe is a one-cycle enable in the system clock domain. Each tick sets a periodic flag. When the interrupt enable is on, the flag drives an interrupt request. The selected rate can also appear as a 50% duty square wave on an output pin.

Software sets the block up through two 8-bit registers, written with a simple strobe, select and data bus. The rate register holds a 4-bit rate code in bits 3:0 and a 3-bit divider mode in bits 6:4. The enable register holds the periodic interrupt enable in bit 6 and the square-wave enable in bit 3. A one-cycle acknowledge input stands for a read of the flag and clears it.

The prescaler counts time-base strobes only. Any write to the rate register restarts it from zero, so a new rate takes effect with a clean first period.

Top module: `periodic_tick_gen`

## Requirements
- R1: Rate code 0 produces no tick: the flag never sets and the square-wave output stays low.
- R2: For rate codes n = 3 to 15, a tick occurs every 2^(n-1) time-base strobes, counted from the last write to the rate register.
- R3: Rate code 1 gives a tick every 128 strobes (256 Hz) and rate code 2 a tick every 256 strobes (128 Hz).
- R4: The divider mode field (bits 6:4 of the rate register) runs the prescaler only at value 3'b010. Every other value holds the prescaler cleared: no tick, and the square wave stays low.
- R5: The interrupt request is high exactly while the flag is set and bit 6 of the enable register is 1. With that bit at 0 the flag still sets, but the request stays low.
- R6: With bit 3 of the enable register set, the square-wave output is low for the first half of each period (in strobes) and high for the second half. It falls at each tick. With the bit clear, the output is held low.
- R7: A tick sets the flag in the cycle after the strobe that completes the period. The flag stays set until the acknowledge is seen. An acknowledge in the same cycle as a tick leaves the flag set.
- R8: A write to the rate register (select 0) clears the prescaler and drives the square wave low. The next tick comes one full period of the new rate later.
- R9: Only cycles with the time-base strobe high advance the prescaler. The period is the same however many idle cycles separate the strobes.
- R10: After reset, all outputs are low, the rate code is 0, the divider mode is halted (3'b000) and both enables are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tbase_stb_i | input | 1 | One-cycle 32768 Hz time-base strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Register select: 0 rate register, 1 enable register |
| wr_data_i | input | 8 | Register write data |
| flag_ack_i | input | 1 | Flag read acknowledge, clears the periodic flag |
| irq_o | output | 1 | Periodic interrupt request |
| sqw_o | output | 1 | Square-wave output |
| flag_o | output | 1 | Periodic flag |

## Verification
The assertions assume that every input is synchronous to the system clock and that the strobe and the acknowledge are each one cycle wide. They also assume that the decoded period changes only together with a prescaler restart, which holds because the rate code and the divider mode live only in the rate register. The stimulus changes inputs only on the falling clock edge. It never places a register write in a strobe cycle, and it raises the acknowledge only in cycles chosen to test clearing or the tick-wins collision. The sweep covers every rate code over two full periods and every divider mode value, with expected periods and square-wave phases worked out from the code arithmetic.

// File: rtl/pitg_pkg.sv
package pitg_pkg;

  localparam int RATE_W   = 4;
  localparam int DV_W     = 3;
  localparam int REG_W    = 8;
  // Half-period counter: code 15 gives 16384 strobes, half is 8192 = 2^13
  localparam int CNT_W    = 13;
  localparam int EXP_W    = $clog2(CNT_W + 1);

  localparam logic [DV_W-1:0] DV_RUN = 3'b010;

  // half-period exponents for the remapped low codes (128 and 256 strobe periods)
  localparam int CODE1_HALF_EXP = 6;
  localparam int CODE2_HALF_EXP = 7;

  // field positions
  localparam int RATE_LSB = 0;
  localparam int DV_LSB   = 4;
  localparam int PIE_BIT  = 6;
  localparam int SQWE_BIT = 3;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic [DV_W-1:0]   dv;
    logic              pie;
    logic              sqwe;
  } cfg_t;

endpackage

// File: rtl/pitg_cfg_regs.sv
module pitg_cfg_regs
  import pitg_pkg::*;
#(
  parameter int DATA_W = REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output cfg_t              cfg_o,
  output logic              restart_o
);

  cfg_t cfg_q;
  cfg_t cfg_d;
  logic wr_rate;
  logic wr_enab;
  logic unused_hi;

  assign wr_rate   = wr_en_i & ~wr_sel_i;
  assign wr_enab   = wr_en_i &  wr_sel_i;
  assign unused_hi = wr_data_i[DATA_W-1];

  always_comb begin
    cfg_d = cfg_q;
    if (wr_rate) begin
      cfg_d.rate = wr_data_i[RATE_LSB +: RATE_W];
      cfg_d.dv   = wr_data_i[DV_LSB +: DV_W];
    end
    if (wr_enab) begin
      cfg_d.pie  = wr_data_i[PIE_BIT];
      cfg_d.sqwe = wr_data_i[SQWE_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_en_i) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o     = cfg_q;
  assign restart_o = wr_rate;

endmodule

// File: rtl/pitg_rate_decode.sv
module pitg_rate_decode
  import pitg_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int EW = EXP_W
) (
  input  logic [RATE_W-1:0] rate_i,
  input  logic [DV_W-1:0]   dv_i,
  output logic              run_o,
  output logic [CW-1:0]     last_o
);

  localparam logic [EW-1:0] EXP1 = EW'(CODE1_HALF_EXP);
  localparam logic [EW-1:0] EXP2 = EW'(CODE2_HALF_EXP);

  logic [EW-1:0] half_exp;

  always_comb begin
    case (rate_i)
      4'd0:    half_exp = '0;
      4'd1:    half_exp = EXP1;
      4'd2:    half_exp = EXP2;
      default: half_exp = EW'(rate_i - 4'd2);
    endcase
  end

  // last count of a half period: 2^half_exp - 1
  assign last_o = ~({CW{1'b1}} << half_exp);
  assign run_o  = (rate_i != '0) && (dv_i == DV_RUN);

endmodule

// File: rtl/pitg_prescaler.sv
module pitg_prescaler
  import pitg_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  input  logic          restart_i,
  input  logic          run_i,
  input  logic [CW-1:0] last_i,
  output logic          phase_o,
  output logic          tick_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          phase_q;
  logic          phase_d;
  logic          cnt_en;
  logic          half_end;

  assign half_end = run_i & strobe_i & ~restart_i & (cnt_q == last_i);
  assign cnt_en   = restart_i | ~run_i | strobe_i;

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (restart_i || !run_i) begin
      cnt_d   = '0;
      phase_d = 1'b0;
    end else if (strobe_i) begin
      if (half_end) begin
        cnt_d   = '0;
        phase_d = ~phase_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign phase_o = phase_q;
  assign tick_o  = half_end & phase_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= last_i)); // R2

  AST_HALT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0) && !phase_q); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && !restart_i && run_i) |=> ($stable(cnt_q) && $stable(phase_q))); // R9

endmodule

// File: rtl/pitg_flag.sv
module pitg_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ack_i,
  input  logic pie_i,
  output logic flag_o,
  output logic irq_o
);

  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (tick_i) begin
      flag_d = 1'b1;
    end else if (ack_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (tick_i || ack_i) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & pie_i;

  AST_FLAG_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> flag_q); // R7

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !tick_i) |=> !flag_q); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !ack_i) |=> flag_q); // R7

endmodule

// File: rtl/periodic_tick_gen.sv
module periodic_tick_gen
  import pitg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tbase_stb_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             flag_ack_i,
  output logic             irq_o,
  output logic             sqw_o,
  output logic             flag_o
);

  logic             rst_meta_q;
  logic             rst_sync_q;
  cfg_t             cfg;
  logic             restart;
  logic             run;
  logic [CNT_W-1:0] last;
  logic             phase;
  logic             tick;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pitg_cfg_regs #(.DATA_W(REG_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_q),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg),
    .restart_o (restart)
  );

  pitg_rate_decode #(.CW(CNT_W), .EW(EXP_W)) u_decode (
    .rate_i (cfg.rate),
    .dv_i   (cfg.dv),
    .run_o  (run),
    .last_o (last)
  );

  pitg_prescaler #(.CW(CNT_W)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_q),
    .strobe_i  (tbase_stb_i),
    .restart_i (restart),
    .run_i     (run),
    .last_i    (last),
    .phase_o   (phase),
    .tick_o    (tick)
  );

  pitg_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_q),
    .tick_i (tick),
    .ack_i  (flag_ack_i),
    .pie_i  (cfg.pie),
    .flag_o (flag_o),
    .irq_o  (irq_o)
  );

  assign sqw_o = phase & cfg.sqwe;

  AST_RESTART_LOW: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    restart |=> !sqw_o); // R8

  AST_NO_TICK_HALTED: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    (!run && !flag_o && !flag_ack_i) |=> !flag_o); // R1

endmodule

// File: tb/periodic_tick_gen_test.sv
module periodic_tick_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk;
  logic       rst_n;
  logic       tbase_stb;
  logic       wr_en;
  logic       wr_sel;
  logic [7:0] wr_data;
  logic       flag_ack;
  logic       irq_o;
  logic       sqw_o;
  logic       flag_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  periodic_tick_gen uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tbase_stb_i (tbase_stb),
    .wr_en_i     (wr_en),
    .wr_sel_i    (wr_sel),
    .wr_data_i   (wr_data),
    .flag_ack_i  (flag_ack),
    .irq_o       (irq_o),
    .sqw_o       (sqw_o),
    .flag_o      (flag_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic a);
    tbase_stb = s;
    flag_ack  = a;
    @(negedge clk);
    tbase_stb = 1'b0;
    flag_ack  = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // drive n strobes with gap idle cycles after each; report first strobe
  // count at which the flag was seen and how often the square wave was high
  task automatic run_stb(input int n, input int gap, output int first, output int sqw_hi);
    first  = 0;
    sqw_hi = 0;
    for (int k = 1; k <= n; k++) begin
      cyc(1'b1, 1'b0);
      if (sqw_o) sqw_hi++;
      if (flag_o && first == 0) first = k;
      for (int g = 0; g < gap; g++) cyc(1'b0, 1'b0);
    end
  endtask

  function automatic logic [7:0] rate_word(input logic [2:0] dv, input logic [3:0] code);
    return {1'b0, dv, code};
  endfunction

  initial begin
    int first;
    int hi;
    rst_n     = 1'b0;
    tbase_stb = 1'b0;
    wr_en     = 1'b0;
    wr_sel    = 1'b0;
    wr_data   = '0;
    flag_ack  = 1'b0;
    repeat (3) @(negedge clk);
    chk(!irq_o && !sqw_o && !flag_o, "R10", "outputs in reset",
        {29'd0, irq_o, sqw_o, flag_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!irq_o && !sqw_o && !flag_o, "R10", "outputs after reset",
        {29'd0, irq_o, sqw_o, flag_o}, 0);
    run_stb(50, 0, first, hi);
    chk(first == 0, "R10", "no tick from reset configuration", first, 0);

    // enables: interrupt (bit 6) and square wave (bit 3)
    wr(1'b1, 8'h48);

    // sweep every nonzero code over two periods
    for (int code = 1; code <= 15; code++) begin
      int p;
      int half;
      int bad_f;
      int bad_s;
      int bad_i;
      int act_s;
      int exp_s;
      p     = (code == 1) ? 128 : (code == 2) ? 256 : (1 << (code - 1));
      half  = p / 2;
      bad_f = 0;
      bad_s = 0;
      bad_i = 0;
      act_s = 0;
      exp_s = 0;
      wr(1'b0, rate_word(3'b010, 4'(code)));
      cyc(1'b0, 1'b1);
      for (int k = 1; k <= 2 * p; k++) begin
        bit ef;
        bit es;
        cyc(1'b1, 1'b0);
        ef = ((k % p) == 0);
        es = ((k % p) >= half);
        if (flag_o != ef) bad_f++;
        if (sqw_o != es) begin
          if (bad_s == 0) begin act_s = int'(sqw_o); exp_s = int'(es); end
          bad_s++;
        end
        if (irq_o != flag_o) bad_i++;
        if (ef) cyc(1'b0, 1'b1);
      end
      if (code < 3)
        chk(bad_f == 0, "R3", $sformatf("code %0d tick period mismatches", code), bad_f, 0);
      else
        chk(bad_f == 0, "R2", $sformatf("code %0d tick period mismatches", code), bad_f, 0);
      chk(bad_s == 0, "R6", $sformatf("code %0d square-wave phase (first bad value)", code),
          act_s, exp_s);
      chk(bad_i == 0, "R5", $sformatf("code %0d irq differs from flag", code), bad_i, 0);
    end
    chk(!flag_o, "R7", "flag cleared by acknowledge", int'(flag_o), 0);

    // rate code 0
    wr(1'b0, rate_word(3'b010, 4'd0));
    cyc(1'b0, 1'b1);
    run_stb(300, 0, first, hi);
    chk(first == 0, "R1", "code 0 tick", first, 0);
    chk(hi == 0, "R1", "code 0 square-wave high count", hi, 0);

    // divider mode values other than 3'b010 halt
    for (int dv = 0; dv < 8; dv++) begin
      if (dv != 2) begin
        wr(1'b0, rate_word(3'(dv), 4'd3));
        cyc(1'b0, 1'b1);
        run_stb(40, 0, first, hi);
        chk(first == 0 && hi == 0, "R4", $sformatf("divider mode %0d first tick", dv), first, 0);
      end
    end
    wr(1'b0, rate_word(3'b010, 4'd3));
    run_stb(10, 0, first, hi);
    chk(first == 4, "R4", "divider run mode restores ticks", first, 4);

    // interrupt enable clear: flag sets, irq stays low
    wr(1'b1, 8'h08);
    wr(1'b0, rate_word(3'b010, 4'd3));
    cyc(1'b0, 1'b1);
    run_stb(4, 0, first, hi);
    chk(first == 4, "R5", "flag sets with irq disabled", first, 4);
    chk(!irq_o, "R5", "irq masked", int'(irq_o), 0);

    // square-wave enable clear
    wr(1'b1, 8'h40);
    wr(1'b0, rate_word(3'b010, 4'd5));
    cyc(1'b0, 1'b1);
    run_stb(40, 0, first, hi);
    chk(hi == 0, "R6", "square wave held low when disabled", hi, 0);
    chk(first == 16, "R2", "code 5 tick with square wave off", first, 16);

    // acknowledge colliding with a tick
    wr(1'b1, 8'h48);
    wr(1'b0, rate_word(3'b010, 4'd3));
    cyc(1'b0, 1'b1);
    run_stb(3, 0, first, hi);
    cyc(1'b1, 1'b1);
    chk(flag_o, "R7", "tick wins over acknowledge", int'(flag_o), 1);
    cyc(1'b0, 1'b1);
    chk(!flag_o, "R7", "later acknowledge clears", int'(flag_o), 0);

    // restart on rate register write
    wr(1'b0, rate_word(3'b010, 4'd6));
    cyc(1'b0, 1'b1);
    run_stb(20, 0, first, hi);
    chk(sqw_o, "R6", "square wave high in second half", int'(sqw_o), 1);
    wr(1'b0, rate_word(3'b010, 4'd6));
    chk(!sqw_o, "R8", "square wave low after rewrite", int'(sqw_o), 0);
    run_stb(40, 0, first, hi);
    chk(first == 32, "R8", "first tick after rewrite", first, 32);

    // enable register write does not restart
    wr(1'b0, rate_word(3'b010, 4'd4));
    cyc(1'b0, 1'b1);
    run_stb(5, 0, first, hi);
    wr(1'b1, 8'h48);
    run_stb(3, 0, first, hi);
    chk(first == 3, "R8", "enable write keeps prescaler", first, 3);

    // idle cycles between strobes do not advance the prescaler
    cyc(1'b0, 1'b1);
    wr(1'b0, rate_word(3'b010, 4'd4));
    run_stb(12, 2, first, hi);
    chk(first == 8, "R9", "strobes to tick with gaps", first, 8);
    cyc(1'b0, 1'b1);
    wr(1'b0, rate_word(3'b010, 4'd3));
    for (int i = 0; i < 20; i++) cyc(1'b0, 1'b0);
    chk(!flag_o, "R9", "no tick without strobes", int'(flag_o), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule